// File: doc/BRIEF.md
# Infrared Pulse Duration Capture Queue

This block times the envelope of a demodulated infrared receiver signal. The input is brought into the clock domain through two flip-flops. While the signal is high a burst (a mark) is in progress, and while it is low the line is idle (a space). A prescaler turns the system clock into a fixed tick, which is 1 µs for a 72 MHz clock divided by 72. A free-running 16-bit tick counter timestamps every edge. Durations are differences of timestamps taken modulo 2^16.

When a mark ends, its length is held as pending. The next rising edge completes the pair: the mark length goes into bits 31:16 of a word, the gap goes into bits 15:0, and the word is pushed into a small circular queue. If the gap grows to the timeout count before a new burst starts, the pending mark is pushed at once with an all-ones gap field, which stands for an unbounded space. A consumer drains the queue through a valid/ready port. Carrier demodulation and protocol decoding are done elsewhere.

Top module: `ir_pulse_capture`

## Requirements
- R1: After reset the queue is empty, `rdValid` is low and `rdData` is zero.
- R2: The mark field counts the ticks between a rising and the next falling edge of the synchronized input, with one tick every `TICK_DIV` clock cycles. The high level means a burst.
- R3: A rising edge that follows a completed mark pushes one word: the mark length in bits 31:16 and, in bits 15:0, the ticks from that mark's falling edge to this rising edge, modulo 2^16.
- R4: When a mark is pending and `TIMEOUT` ticks pass after its falling edge with no rising edge, the word {mark, 16'hFFFF} is pushed. A rising edge that comes in the very tick the gap reaches `TIMEOUT` wins, and the real gap is reported.
- R5: A word is pushed only while a mark is pending, and each push clears the pending mark. A rising edge that comes after a timeout push therefore pushes nothing.
- R6: Entries leave in arrival order. The read and write indices wrap modulo `DEPTH`, and at most `DEPTH`-1 entries are held.
- R7: A push that takes the last usable slot stores 32'hFFFF_FFFF in place of its word, as an overflow marker. Pushes that arrive while the queue is full are dropped.
- R8: `rdValid` is high whenever the queue holds an entry. The head entry is removed on a cycle where `rdValid` and `rdReady` are both high, and it stays stable otherwise.
- R9: While the queue is empty, `rdData` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irIn | input | 1 | Demodulated receiver level, high during a burst (asynchronous) |
| rdReady | input | 1 | Consumer accepts the head entry |
| rdValid | output | 1 | Queue holds at least one entry |
| rdData | output | 32 | Head entry {mark, space}, zero when empty |

## Verification
The assertions check on every cycle that:
- the tick counter only ever steps by one;
- every push happens with a mark pending and clears it;
- a timeout push fires exactly at the timeout count;
- a dropped push leaves the write index alone;
- the queue is full right after the marker goes in;
- the head entry holds still while it is not accepted.

Only the bench scenarios can show that the measured values are right, which takes concrete pulse trains: single-cycle pulses, a gap one tick short of the timeout, a gap equal to it and a gap one tick past it, a divided tick, and the exact order of entries and the marker position after an overflow.

// File: rtl/ir_capture_pkg.sv
package ir_capture_pkg;

  // Strobes sent from the control module to the datapath, all valid for one cycle
  typedef struct packed {
    logic markStart;   // synchronized rising edge: timestamp the start of a burst
    logic markEnd;     // falling edge that ends a burst: latch the mark length
    logic pushPair;    // rising edge with a mark pending: push {mark, gap}
    logic pushTimeout; // gap reached the timeout: push {mark, all ones}
  } irStrobes_t;

endpackage

// File: rtl/irCaptureCtrl.sv
module irCaptureCtrl
  import ir_capture_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TIMEOUT = 30000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             irIn,
  input  logic [CNT_W-1:0] elapsed,
  output irStrobes_t       strobes
);

  // syncQ[0..1] form the two-flop synchronizer; syncQ[2] holds the previous level
  logic [2:0] syncQ;
  logic       rise, fall;
  logic       markActive;
  logic       pending;
  logic       timeUp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], irIn};
  end

  assign rise   = syncQ[1] & ~syncQ[2];
  assign fall   = ~syncQ[1] & syncQ[2];
  assign timeUp = elapsed >= CNT_W'(TIMEOUT);

  always_comb begin
    strobes             = '0;
    strobes.markStart   = rise;
    strobes.markEnd     = fall & markActive;
    strobes.pushPair    = rise & pending;
    strobes.pushTimeout = pending & ~rise & timeUp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      markActive <= 1'b0;
      pending    <= 1'b0;
    end else begin
      if (rise)      markActive <= 1'b1;
      else if (fall) markActive <= 1'b0;

      if (strobes.pushPair || strobes.pushTimeout) pending <= 1'b0;
      else if (strobes.markEnd)                    pending <= 1'b1;
    end
  end

  // R5: every push needs a pending mark and leaves none behind
  assert_push_needs_pending_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pushPair || strobes.pushTimeout) |-> pending);
  assert_push_clears_pending_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pushPair || strobes.pushTimeout) |=> !pending);
  // R4: the gap is checked every cycle, so a timeout push sees exactly the limit
  assert_timeout_exact_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pushTimeout |-> (elapsed == CNT_W'(TIMEOUT)));

endmodule

// File: rtl/irPulseQueue.sv
module irPulseQueue #(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushEn,
  input  logic [WORD_W-1:0] pushWord,
  input  logic              rdReady,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [WORD_W-1:0] store [DEPTH];
  logic [IDX_W-1:0]  wrIdx, rdIdx, wrNext, wrNext2;
  logic              full, lastSlot, accept, pop;

  assign wrNext   = wrIdx + IDX_W'(1);
  assign wrNext2  = wrIdx + IDX_W'(2);
  assign full     = (wrNext == rdIdx);
  assign lastSlot = (wrNext2 == rdIdx);
  assign accept   = pushEn & ~full;
  assign rdValid  = (wrIdx != rdIdx);
  assign pop      = rdValid & rdReady;
  assign rdData   = rdValid ? store[rdIdx] : '0;

  always_ff @(posedge clk) begin
    if (accept) store[wrIdx] <= lastSlot ? '1 : pushWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdIdx <= '0;
    end else begin
      if (accept) wrIdx <= wrNext;
      if (pop)    rdIdx <= rdIdx + IDX_W'(1);
    end
  end

  // R8: a head entry that is not accepted stays in place
  assert_head_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData)));
  // R6: a pop advances the read index by exactly one slot
  assert_pop_advance_R6: assert property (@(posedge clk) disable iff (!rstN)
    pop |=> (rdIdx == $past(rdIdx) + IDX_W'(1)));
  // R7: a push into a full queue leaves the write index alone
  assert_drop_when_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && full) |=> (wrIdx == $past(wrIdx)));
  // R7: once the marker is in and nothing is popped, the queue is full
  assert_full_after_marker_R7: assert property (@(posedge clk) disable iff (!rstN)
    (accept && lastSlot && !pop) |=> (wrIdx + IDX_W'(1) == rdIdx));

endmodule

// File: rtl/irCaptureDatapath.sv
module irCaptureDatapath
  import ir_capture_pkg::*;
#(
  parameter int TICK_DIV = 72,
  parameter int CNT_W    = 16,
  parameter int DEPTH    = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  irStrobes_t         strobes,
  input  logic               rdReady,
  output logic [CNT_W-1:0]   elapsed,
  output logic               rdValid,
  output logic [2*CNT_W-1:0] rdData
);

  localparam int WORD_W = 2 * CNT_W;

  logic              tick;
  logic [CNT_W-1:0]  tickCnt, startStamp, endStamp, markLen;
  logic              pushEn;
  logic [WORD_W-1:0] pushWord;

  generate
    if (TICK_DIV == 1) begin : g_noDiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DIV_W = $clog2(TICK_DIV);
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                             divCnt <= '0;
        else if (divCnt == DIV_W'(TICK_DIV-1)) divCnt <= '0;
        else                                   divCnt <= divCnt + DIV_W'(1);
      end
      assign tick = (divCnt == DIV_W'(TICK_DIV-1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt    <= '0;
      startStamp <= '0;
      endStamp   <= '0;
      markLen    <= '0;
    end else begin
      if (tick)              tickCnt    <= tickCnt + CNT_W'(1);
      if (strobes.markStart) startStamp <= tickCnt;
      if (strobes.markEnd) begin
        markLen  <= tickCnt - startStamp;
        endStamp <= tickCnt;
      end
    end
  end

  assign elapsed  = tickCnt - endStamp;
  assign pushEn   = strobes.pushPair | strobes.pushTimeout;
  assign pushWord = {markLen, strobes.pushTimeout ? {CNT_W{1'b1}} : elapsed};

  irPulseQueue #(
    .DEPTH  (DEPTH),
    .WORD_W (WORD_W)
  ) u_queue (
    .clk      (clk),
    .rstN     (rstN),
    .pushEn   (pushEn),
    .pushWord (pushWord),
    .rdReady  (rdReady),
    .rdValid  (rdValid),
    .rdData   (rdData)
  );

  // R2: the timebase advances by at most one count per clock
  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tickCnt == $past(tickCnt)) || (tickCnt == $past(tickCnt) + CNT_W'(1)));

endmodule

// File: rtl/ir_pulse_capture.sv
module ir_pulse_capture
  import ir_capture_pkg::*;
#(
  parameter int TICK_DIV = 72,
  parameter int CNT_W    = 16,
  parameter int TIMEOUT  = 30000,
  parameter int DEPTH    = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               irIn,
  input  logic               rdReady,
  output logic               rdValid,
  output logic [2*CNT_W-1:0] rdData
);

  irStrobes_t       strobes;
  logic [CNT_W-1:0] elapsed;

  irCaptureCtrl #(
    .CNT_W   (CNT_W),
    .TIMEOUT (TIMEOUT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .irIn    (irIn),
    .elapsed (elapsed),
    .strobes (strobes)
  );

  irCaptureDatapath #(
    .TICK_DIV (TICK_DIV),
    .CNT_W    (CNT_W),
    .DEPTH    (DEPTH)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .rdReady (rdReady),
    .elapsed (elapsed),
    .rdValid (rdValid),
    .rdData  (rdData)
  );

  // R9: an empty queue presents zero on the data port
  assert_empty_reads_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));

endmodule

// File: tb/tb_ir_pulse_capture.sv
module tb_ir_pulse_capture;

  localparam int CLK_PERIOD = 10;
  localparam int TOUT       = 50;
  localparam int NVEC       = 9;
  // {mark cycles, gap cycles}; the last gap is replaced by a long idle
  localparam int unsigned VEC [NVEC][2] = '{
    '{3, 4}, '{10, 2}, '{1, 1}, '{25, 49}, '{2, 30},
    '{7, 13}, '{6, 50}, '{60, 5}, '{4, 0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irIn = 1'b0, rdReady = 1'b0, rdValid;
  logic [31:0] rdData;
  logic        irIn2 = 1'b0, rdReady2 = 1'b0, rdValid2;
  logic [31:0] rdData2;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_pulse_capture #(.TICK_DIV(1), .TIMEOUT(TOUT), .DEPTH(32)) dut (
    .clk(clk), .rstN(rstN), .irIn(irIn), .rdReady(rdReady),
    .rdValid(rdValid), .rdData(rdData));

  ir_pulse_capture #(.TICK_DIV(4), .TIMEOUT(TOUT), .DEPTH(32)) dutDiv (
    .clk(clk), .rstN(rstN), .irIn(irIn2), .rdReady(rdReady2),
    .rdValid(rdValid2), .rdData(rdData2));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic pulse(input int m, input int s);
    irIn = 1'b1;
    repeat (m) @(negedge clk);
    irIn = 1'b0;
    repeat (s) @(negedge clk);
  endtask

  task automatic popCheck(input string req, input logic [31:0] exp);
    check({req, " valid"}, {31'd0, rdValid}, 32'd1);
    check(req, rdData, exp);
    rdReady = 1'b1;
    @(negedge clk);
    rdReady = 1'b0;
  endtask

  task automatic emptyCheck(input string req);
    check({req, " valid"}, {31'd0, rdValid}, 32'd0);
    check({req, " data"}, rdData, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    emptyCheck("R1 reset");
    check("R1 reset div", {rdValid2, 31'd0} | rdData2, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R4: table of pulse trains, drained in order (R6)
    for (int i = 0; i < NVEC; i++)
      pulse(int'(VEC[i][0]), (i == NVEC-1) ? 80 : int'(VEC[i][1]));
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] expGap;
      expGap = (i == NVEC-1) ? 16'hFFFF : 16'(VEC[i][1]);
      popCheck("R3/R6 table entry", {16'(VEC[i][0]), expGap});
    end
    emptyCheck("R9 after table");

    // R4 R5: gap one past the limit times out; the next rising edge pushes nothing
    pulse(5, TOUT + 1);
    pulse(3, 80);
    popCheck("R4 timeout entry", {16'd5, 16'hFFFF});
    popCheck("R5 only timeout of second mark", {16'd3, 16'hFFFF});
    emptyCheck("R5 no push from post-timeout edge");

    // R8: head held while not accepted
    pulse(9, 80);
    for (int k = 0; k < 5; k++) begin
      check("R8 hold valid", {31'd0, rdValid}, 32'd1);
      check("R8 hold data", rdData, {16'd9, 16'hFFFF});
      @(negedge clk);
    end
    popCheck("R8 pop", {16'd9, 16'hFFFF});
    emptyCheck("R8 after pop");

    // R7: 32 pushes without reading: 30 words, the marker, then drops
    for (int i = 0; i < 32; i++) pulse(2, (i == 31) ? 80 : 2);
    for (int i = 0; i < 30; i++) popCheck("R7 stored word", {16'd2, 16'd2});
    popCheck("R7 overflow marker", 32'hFFFF_FFFF);
    emptyCheck("R7 drops after full");
    pulse(4, 80);
    popCheck("R6 recovery after wrap", {16'd4, 16'hFFFF});

    // R2: divided tick, lengths in ticks of four cycles
    irIn2 = 1'b1; repeat (40) @(negedge clk);
    irIn2 = 1'b0; repeat (20) @(negedge clk);
    irIn2 = 1'b1; repeat (8) @(negedge clk);
    irIn2 = 1'b0; repeat (260) @(negedge clk);
    check("R2 divided tick first", rdData2, {16'd10, 16'd5});
    rdReady2 = 1'b1; @(negedge clk); rdReady2 = 1'b0;
    check("R2 divided tick timeout", rdData2, {16'd2, 16'hFFFF});
    rdReady2 = 1'b1; @(negedge clk); rdReady2 = 1'b0;
    check("R9 divided empty", {rdValid2, 31'd0} | rdData2, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule